// File: doc/BRIEF.md
# Clock Digit Image Stream Generator

This block renders the time of day as a horizontal strip of glyph images and sends the strip as one frame on a 64-bit AXI4-Stream master. It keeps its own time-of-day counter in BCD, with hours, minutes, seconds and hundredths of a second. A setting port loads that counter, and a read-out port shows its value. Glyph bitmaps live in an on-chip memory of 4-bit opacity pixels, which is filled through a simple word-write port.

When the host pulses the trigger while the block is idle, the block copies the current time and the format select into internal registers. It then scans the frame line by line from top to bottom. Each line runs across the character positions from left to right, and each position is read one memory word at a time. Every word of eight opacity pixels becomes one stream beat of eight 8-bit pixels.

In the long format the strip reads hours:minutes:seconds:hundredths, which is 11 positions. In the short format it reads hours:minutes:seconds, which is 8 positions. A downstream stage uses the opacity values to colour and blend the digits.

Top module: `glyph_clock_stream`

## Requirements
- R1: While reset is held and in the cycle after it, `busy` and `outValid` are 0 and `timeNow` reads 0.
- R2: `timeNow` holds eight BCD digits: hour tens in [31:28], hour units in [27:24], minute tens in [23:20], minute units in [19:16], second tens in [15:12], second units in [11:8], hundredths tens in [7:4] and hundredths units in [3:0]. It advances by one hundredth every `CS_CYCLES` clock cycles.
- R3: Hundredths wrap from 99 to 00, seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. A cycle with `setEn` high loads `setTime` and restarts the hundredth period.
- R4: A `trigger` seen while idle raises `busy` in the next cycle. It also captures the time and `fmtLong` for the frame. `busy` stays high until the final beat is accepted. A `trigger` that arrives while `busy` is high has no effect on the stream.
- R5: A frame holds `GLYPH_H` lines. The lines are scanned top first. Each line covers the character positions from left to right, and each position contributes `GLYPH_W/8` beats. With `fmtLong`=1 the positions are H H : M M : S S : C C (11 positions). With `fmtLong`=0 they are H H : M M : S S (8 positions).
- R6: The glyph index of a position is the BCD digit it shows, or 10 for a colon. Beat k of a position's row r reads the word at index×(`GLYPH_H`×`GLYPH_W`/8) + r×(`GLYPH_W`/8) + k. Within a word, bits [3:0] hold the leftmost pixel.
- R7: Each 4-bit opacity value v leaves the block as the byte (v<<4)+15. The leftmost pixel of a beat sits in `outData[7:0]`, and each following pixel sits 8 bits higher.
- R8: `outLast` is 1 on the final beat of a frame and 0 on every other beat.
- R9: While `outValid` is 1 and `outReady` is 0, the block holds `outValid`, `outData` and `outLast` unchanged in the next cycle.
- R10: With `outReady` held at 1, the block sends one beat per cycle. `busy` is then high for exactly (beats per frame + 1) cycles.
- R11: A change of the time counter during a frame, including a full rollover, does not change any digit of that frame.
- R12: A cycle with `memWe` high stores `memData` at `memAddr`, and later frames show the stored pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigger | input | 1 | Starts a frame when the block is idle |
| fmtLong | input | 1 | 1 selects the 11-position format, 0 the 8-position format |
| busy | output | 1 | A frame is in progress |
| setEn | input | 1 | Loads `setTime` into the time counter |
| setTime | input | 32 | BCD time to load |
| timeNow | output | 32 | Current BCD time |
| memWe | input | 1 | Glyph memory write enable |
| memAddr | input | AW | Glyph memory word address |
| memData | input | 32 | Eight 4-bit pixels, leftmost in [3:0] |
| outValid | output | 1 | Stream TVALID |
| outReady | input | 1 | Stream TREADY |
| outData | output | 64 | Stream TDATA, eight 8-bit pixels |
| outLast | output | 1 | Stream TLAST, final beat of the frame |

## Verification
The bench builds the block with 4-line, 16-pixel-wide glyphs and a 3-cycle hundredth period. A long frame is then 88 beats and a short frame 64 beats, so complete frames finish in a short run. The short period lets the full 23:59:59:99 rollover happen in the middle of a frame that the bench slows with random backpressure. Glyph rows two words wide exercise the column step inside a position as well as the steps to the next position and the next line.

// File: rtl/glyph_clock_pkg.sv
package glyph_clock_pkg;

  localparam int GLYPH_COUNT = 11;
  localparam int COLON_IDX   = 10;

  typedef struct packed {
    logic issue;  // fetch one word and load the output register
    logic last;   // the word being fetched ends the frame
  } beatCtl_t;

  function automatic logic [63:0] widenWord(input logic [31:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = {w[i*4 +: 4], 4'hF};
    return r;
  endfunction

endpackage

// File: rtl/glyph_clock_time.sv
module glyph_clock_time #(
  parameter int CS_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        setEn,
  input  logic [31:0] setTime,
  output logic [31:0] timeNow
);
  localparam int DW = (CS_CYCLES > 1) ? $clog2(CS_CYCLES) : 1;

  logic [DW-1:0] div;
  logic          tick;
  logic [31:0]   nextT;

  assign tick = (div == DW'(CS_CYCLES - 1));

  always_comb begin
    nextT = timeNow;
    if (timeNow[3:0] != 4'd9) nextT[3:0] = timeNow[3:0] + 4'd1;
    else begin
      nextT[3:0] = 4'd0;
      if (timeNow[7:4] != 4'd9) nextT[7:4] = timeNow[7:4] + 4'd1;
      else begin
        nextT[7:4] = 4'd0;
        if (timeNow[11:8] != 4'd9) nextT[11:8] = timeNow[11:8] + 4'd1;
        else begin
          nextT[11:8] = 4'd0;
          if (timeNow[15:12] != 4'd5) nextT[15:12] = timeNow[15:12] + 4'd1;
          else begin
            nextT[15:12] = 4'd0;
            if (timeNow[19:16] != 4'd9) nextT[19:16] = timeNow[19:16] + 4'd1;
            else begin
              nextT[19:16] = 4'd0;
              if (timeNow[23:20] != 4'd5) nextT[23:20] = timeNow[23:20] + 4'd1;
              else begin
                nextT[23:20] = 4'd0;
                if (timeNow[31:28] == 4'd2 && timeNow[27:24] == 4'd3) nextT[31:24] = 8'h00;
                else if (timeNow[27:24] == 4'd9) begin
                  nextT[27:24] = 4'd0;
                  nextT[31:28] = timeNow[31:28] + 4'd1;
                end else nextT[27:24] = timeNow[27:24] + 4'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow <= '0;
      div     <= '0;
    end else if (setEn) begin
      timeNow <= setTime;
      div     <= '0;
    end else if (tick) begin
      timeNow <= nextT;
      div     <= '0;
    end else begin
      div <= div + DW'(1);
    end
  end
endmodule

// File: rtl/glyph_clock_ctrl.sv
module glyph_clock_ctrl
  import glyph_clock_pkg::*;
#(
  parameter int GLYPH_H = 12,
  parameter int GLYPH_W = 16,
  parameter int AW      = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  input  logic          fmtLong,
  input  logic [31:0]   timeNow,
  input  logic          outValid,
  input  logic          outReady,
  input  logic          outLast,
  output logic          busy,
  output beatCtl_t      strobe,
  output logic [AW-1:0] rdAddr
);
  localparam int WPR    = GLYPH_W / 8;
  localparam int GWORDS = GLYPH_H * WPR;
  localparam int CW     = (WPR > 1) ? $clog2(WPR) : 1;
  localparam int RW     = (GLYPH_H > 1) ? $clog2(GLYPH_H) : 1;

  logic          issuedAll, fmtQ;
  logic [31:0]   snap;
  logic [RW-1:0] row;
  logic [3:0]    pos, posLast, glyph;
  logic [CW-1:0] col;
  logic          colEnd, lastBeat;
  int unsigned   addrFull;

  assign posLast  = fmtQ ? 4'd10 : 4'd7;
  assign colEnd   = (col == CW'(WPR - 1));
  assign lastBeat = colEnd && (pos == posLast) && (row == RW'(GLYPH_H - 1));

  always_comb begin
    case (pos)
      4'd0:    glyph = snap[31:28];
      4'd1:    glyph = snap[27:24];
      4'd3:    glyph = snap[23:20];
      4'd4:    glyph = snap[19:16];
      4'd6:    glyph = snap[15:12];
      4'd7:    glyph = snap[11:8];
      4'd9:    glyph = snap[7:4];
      4'd10:   glyph = snap[3:0];
      default: glyph = 4'(COLON_IDX);
    endcase
    addrFull = int'(glyph) * GWORDS + int'(row) * WPR + int'(col);
    rdAddr   = addrFull[AW-1:0];
  end

  assign strobe.issue = busy && !issuedAll && (!outValid || outReady);
  assign strobe.last  = lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      issuedAll <= 1'b0;
      fmtQ      <= 1'b0;
      snap      <= '0;
      row       <= '0;
      pos       <= '0;
      col       <= '0;
    end else if (!busy) begin
      if (trigger) begin
        busy      <= 1'b1;
        issuedAll <= 1'b0;
        fmtQ      <= fmtLong;
        snap      <= timeNow;
        row       <= '0;
        pos       <= '0;
        col       <= '0;
      end
    end else begin
      if (strobe.issue) begin
        if (lastBeat) issuedAll <= 1'b1;
        if (colEnd) begin
          col <= '0;
          if (pos == posLast) begin
            pos <= '0;
            row <= row + RW'(1);
          end else pos <= pos + 4'd1;
        end else col <= col + CW'(1);
      end
      if (outValid && outReady && outLast) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/glyph_clock_datapath.sv
module glyph_clock_datapath
  import glyph_clock_pkg::*;
#(
  parameter int MEM_WORDS = 264,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  input  logic [31:0]   memData,
  input  beatCtl_t      strobe,
  input  logic [AW-1:0] rdAddr,
  input  logic          outReady,
  output logic          outValid,
  output logic [63:0]   outData,
  output logic          outLast
);
  logic [31:0] mem [MEM_WORDS];
  logic [31:0] rdWord;

  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= memData;
    if (strobe.issue) rdWord <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else if (strobe.issue) begin
      outValid <= 1'b1;
      outLast  <= strobe.last;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign outData = widenWord(rdWord);
endmodule

// File: rtl/glyph_clock_stream.sv
module glyph_clock_stream
  import glyph_clock_pkg::*;
#(
  parameter int  GLYPH_H   = 12,
  parameter int  GLYPH_W   = 16,
  parameter int  CS_CYCLES = 1000,
  localparam int MEM_WORDS = GLYPH_COUNT * GLYPH_H * (GLYPH_W / 8),
  localparam int AW        = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  input  logic          fmtLong,
  output logic          busy,
  input  logic          setEn,
  input  logic [31:0]   setTime,
  output logic [31:0]   timeNow,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  input  logic [31:0]   memData,
  output logic          outValid,
  input  logic          outReady,
  output logic [63:0]   outData,
  output logic          outLast
);
  beatCtl_t      strobe;
  logic [AW-1:0] rdAddr;

  glyph_clock_time #(.CS_CYCLES(CS_CYCLES)) uTime (
    .clk(clk), .rstN(rstN), .setEn(setEn), .setTime(setTime), .timeNow(timeNow)
  );

  glyph_clock_ctrl #(.GLYPH_H(GLYPH_H), .GLYPH_W(GLYPH_W), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .fmtLong(fmtLong), .timeNow(timeNow),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .busy(busy),
    .strobe(strobe), .rdAddr(rdAddr)
  );

  glyph_clock_datapath #(.MEM_WORDS(MEM_WORDS), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .strobe(strobe), .rdAddr(rdAddr), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outLast(outLast)
  );
endmodule

// File: rtl/glyph_clock_stream_sva.sv
module glyph_clock_stream_sva (
  input logic        clk,
  input logic        rstN,
  input logic        trigger,
  input logic        busy,
  input logic [31:0] timeNow,
  input logic        outValid,
  input logic        outReady,
  input logic [63:0] outData,
  input logic        outLast
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid); // R4
  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !busy) |=> busy); // R4
  AST_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(outValid && outReady && outLast)) |=> busy); // R4
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast))); // R9
  AST_END_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !busy); // R8
  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (timeNow[3:0] <= 4'd9 && timeNow[7:4] <= 4'd9 && timeNow[11:8] <= 4'd9 &&
     timeNow[15:12] <= 4'd5 && timeNow[19:16] <= 4'd9 && timeNow[23:20] <= 4'd5)); // R2
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (timeNow[31:24] <= 8'h23 && timeNow[27:24] <= 4'd9)); // R3
endmodule

bind glyph_clock_stream glyph_clock_stream_sva uSva (
  .clk(clk), .rstN(rstN), .trigger(trigger), .busy(busy), .timeNow(timeNow),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
);

// File: tb/sim_glyph_clock_stream.sv
`timescale 1ns/1ps
module sim_glyph_clock_stream;
  localparam int GH = 4;
  localparam int GW = 16;
  localparam int CSC = 3;
  localparam int WPR = GW / 8;
  localparam int GWORDS = GH * WPR;
  localparam int MW = 11 * GWORDS;
  localparam int AW = $clog2(MW);

  logic clk = 1'b0, rstN = 1'b0, trigger = 1'b0, fmtLong = 1'b0, busy;
  logic setEn = 1'b0, memWe = 1'b0, outValid, outReady = 1'b0, outLast;
  logic [31:0] setTime = '0, timeNow, memData = '0;
  logic [AW-1:0] memAddr = '0;
  logic [63:0] outData;

  int checks = 0, fails = 0, readyMode = 0;
  logic [31:0] gmem [MW];
  logic [64:0] q[$];
  bit mBusy = 0, prevValid = 0, prevReady = 0, prevLast = 0;
  logic [63:0] prevData = '0;
  int mTotal = 0, mDiv = 0;

  always #2 clk = ~clk;

  glyph_clock_stream #(.GLYPH_H(GH), .GLYPH_W(GW), .CS_CYCLES(CSC)) u0 (
    .clk(clk), .rstN(rstN), .trigger(trigger), .fmtLong(fmtLong), .busy(busy),
    .setEn(setEn), .setTime(setTime), .timeNow(timeNow), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] toBcd(input int t);
    int c, s, m, h;
    c = t % 100; s = (t / 100) % 60; m = (t / 6000) % 60; h = t / 360000;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
            4'(s / 10), 4'(s % 10), 4'(c / 10), 4'(c % 10)};
  endfunction

  function automatic int fromBcd(input logic [31:0] b);
    return (b[31:28] * 10 + b[27:24]) * 360000 + (b[23:20] * 10 + b[19:16]) * 6000 +
           (b[15:12] * 10 + b[11:8]) * 100 + b[7:4] * 10 + b[3:0];
  endfunction

  // Expected frame per R5, R6, R7, R8
  task automatic buildFrame(input bit lng, input int t);
    int g[11];
    int c, s, m, h, npos, total, n;
    logic [31:0] w;
    logic [63:0] beat;
    c = t % 100; s = (t / 100) % 60; m = (t / 6000) % 60; h = t / 360000;
    g = '{h / 10, h % 10, 10, m / 10, m % 10, 10, s / 10, s % 10, 10, c / 10, c % 10};
    npos = lng ? 11 : 8;
    total = GH * npos * WPR;
    n = 0;
    for (int r = 0; r < GH; r++)
      for (int p = 0; p < npos; p++)
        for (int k = 0; k < WPR; k++) begin
          w = gmem[g[p] * GWORDS + r * WPR + k];
          for (int x = 0; x < 8; x++) beat[x*8 +: 8] = 8'((int'(w[x*4 +: 4]) << 4) + 15);
          n++;
          q.push_back({(n == total), beat});
        end
  endtask

  always @(negedge clk) begin
    logic [64:0] e;
    bit preBusy;
    if (!rstN) begin
      mBusy = 0; mTotal = 0; mDiv = 0; q.delete(); prevValid = 0;
    end else begin
      chk(busy == mBusy, "R4", "busy", 64'(busy), 64'(mBusy));
      chk(timeNow == toBcd(mTotal), "R2", "timeNow", 64'(timeNow), 64'(toBcd(mTotal)));
      if (outValid) begin
        if (!mBusy) chk(0, "R4", "valid while idle", 64'(outValid), 64'd0);
        else if (q.size() == 0) chk(0, "R5", "extra beat", outData, 64'd0);
        else begin
          chk(outData == q[0][63:0], "R7", "beat data", outData, q[0][63:0]);
          chk(outLast == q[0][64], "R8", "last flag", 64'(outLast), 64'(q[0][64]));
        end
      end
      if (prevValid && !prevReady)
        chk(outValid && outData == prevData && outLast == prevLast, "R9", "held beat",
            outData, prevData);
      prevValid = outValid; prevReady = outReady; prevData = outData; prevLast = outLast;
      preBusy = mBusy;
      if (outValid && outReady && q.size() > 0) begin
        e = q.pop_front();
        if (e[64]) mBusy = 0;
      end
      if (trigger && !preBusy) begin
        buildFrame(fmtLong, mTotal);  // R11: digits fixed at capture
        mBusy = 1;
      end
      if (setEn) begin mTotal = fromBcd(setTime); mDiv = 0; end
      else if (mDiv == CSC - 1) begin mDiv = 0; mTotal = (mTotal + 1) % 8640000; end
      else mDiv++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (readyMode == 0) outReady = 1'b1;
    else outReady = (($urandom % 3) != 0);
  end

  task automatic loadTime(input logic [31:0] v);
    @(posedge clk); #1 setEn = 1'b1; setTime = v;
    @(posedge clk); #1 setEn = 1'b0;
  endtask

  task automatic runFrame(input bit lng, input int mode, input int expCycles, input string tag);
    int cnt;
    readyMode = mode;
    @(posedge clk); #1 trigger = 1'b1; fmtLong = lng;
    @(posedge clk); #1 trigger = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (busy) cnt++; else break;
    end
    if (expCycles > 0) chk(cnt == expCycles, "R10", "busy cycles", 64'(cnt), 64'(expCycles));
    chk(q.size() == 0, "R5", {"beats left ", tag}, 64'(q.size()), 64'd0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !outValid && timeNow == 0, "R1", "reset outputs",
        {31'd0, busy, timeNow}, 64'd0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !outValid && timeNow == 0, "R1", "after release",
        {31'd0, busy, timeNow}, 64'd0);

    // R12: fill glyph memory; word 0 covers the 0 and F nibble corners
    for (int a = 0; a < MW; a++) begin
      logic [31:0] w;
      w = (a == 0) ? 32'hF0B0_0F1E : $urandom;
      gmem[a] = w;
      @(posedge clk); #1 memWe = 1'b1; memAddr = AW'(a); memData = w;
    end
    @(posedge clk); #1 memWe = 1'b0;

    loadTime(32'h1234_5678);
    runFrame(1'b1, 0, GH * 11 * WPR + 1, "long R5");      // R10
    runFrame(1'b0, 0, GH * 8 * WPR + 1, "short R5");      // R10
    runFrame(1'b0, 1, 0, "short backpressure R9");

    // R4: trigger with another format while busy is ignored
    readyMode = 1;
    @(posedge clk); #1 trigger = 1'b1; fmtLong = 1'b1;
    @(posedge clk); #1 trigger = 1'b0;
    repeat (10) @(posedge clk);
    #1 trigger = 1'b1; fmtLong = 1'b0;
    @(posedge clk); #1 trigger = 1'b0;
    forever begin @(negedge clk); if (!busy) break; end
    chk(q.size() == 0, "R4", "ignored trigger", 64'(q.size()), 64'd0);

    // R3: full rollover, explicit check
    loadTime(32'h2359_5999);
    repeat (2) @(negedge clk);
    chk(timeNow == 32'h2359_5999, "R3", "before wrap", 64'(timeNow), 64'h23595999);
    repeat (2) @(negedge clk);
    chk(timeNow == 32'h0, "R3", "hour wrap", 64'(timeNow), 64'h0);

    // R11: rollover in the middle of a slowed frame
    loadTime(32'h2359_5998);
    runFrame(1'b1, 1, 0, "rollover R11");
    chk(timeNow[31:24] == 8'h00, "R11", "time wrapped during frame", 64'(timeNow), 64'h0);

    loadTime(32'h0959_5995);
    runFrame(1'b0, 0, GH * 8 * WPR + 1, "minute carry R6");

    // R12: rewrite the colon glyph, then check a new frame
    for (int a = 10 * GWORDS; a < 11 * GWORDS; a++) begin
      gmem[a] = ~gmem[a];
      @(posedge clk); #1 memWe = 1'b1; memAddr = AW'(a); memData = gmem[a];
    end
    @(posedge clk); #1 memWe = 1'b0;
    runFrame(1'b1, 1, 0, "rewritten R12");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule